// File: doc/BRIEF.md
# Width-Converting DMA Data Mover

This block is the data engine that a channel controller starts with a descriptor: a word-aligned source address and a length in 32-bit words. It fetches the source memory in 64-bit beats over a simple request/response read port, splits each beat into 32-bit words inside a small word FIFO, and hands the words one by one to a peripheral write port. Data always moves from memory to the peripheral.

Writes are paced by a request level from the peripheral. While that level is high and the write port is ready, one word leaves per cycle. The read side and the write side each keep their own address counter. The read counter steps by 8 bytes per beat and the write counter steps by 4 bytes per word, and both are visible as outputs. The mover holds up to two descriptors. The read side runs ahead into the second descriptor, so the write stream continues across the boundary with no idle cycle. An abort input empties the mover at once.

Top module: `dmv_mover`

## Requirements
- R1: After reset `busy`, `rdReq`, `wrValid` and `done` are 0, `startReady` is 1, and `rdAddr` and `wrAddr` are 0.
- R2: Every read request carries an address with bits [2:0] equal to 0. Each accepted request (`rdReq` and `rdReady` high) advances `rdAddr` by 8. The first request of a transfer is the start address with bits [2:0] cleared.
- R3: The words of a transfer are written at the start address, start+4, start+8 and so on. Each word is the memory word at its own byte address: a beat's bits [31:0] hold the word at the beat address and bits [63:32] hold the word at beat address + 4, and the lower half leaves first. A word is held on the port until `wrReady` accepts it.
- R4: When start address bit 2 is 1, the lower half of the first beat is discarded, and the first word written is the upper half.
- R5: When the word count does not fill the final beat, its upper half is discarded, and exactly the programmed number of words is written.
- R6: `wrValid` is never high while `perReq` is low. While `perReq` stays high, words leave on consecutive cycles with no new edge needed.
- R7: A descriptor whose length is 0 is taken (`startValid` with `startReady`) but causes no read request, no write and no `done`.
- R8: At most one read is outstanding. A read is requested only while the FIFO can take a full beat, counting any beat still in flight, so with `FifoDepth` = 8, no writes, and an aligned start, exactly 4 beats are fetched.
- R9: `done` is high for exactly the one cycle after the clock edge that accepts the last word of a transfer.
- R10: Two descriptors can be queued; `startReady` is 0 while both slots are held. When the data is already buffered and `perReq` and `wrReady` stay high, the second transfer's first word is accepted in the cycle right after the first transfer's last word.
- R11: An `abort` cycle drops both queued descriptors, empties the FIFO and clears both address counters. In the following cycle `busy` and `wrValid` are 0 and `startReady` is 1, and a read response still in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| abort | input | 1 | Flush everything, one cycle |
| startValid | input | 1 | Descriptor offered |
| startReady | output | 1 | A descriptor slot is free |
| startAddr | input | 32 | Word-aligned source byte address |
| startLen | input | 16 | Length in 32-bit words, 1 to 0x8000 (0 is dropped) |
| rdReq | output | 1 | Read beat request |
| rdReady | input | 1 | Memory accepts the request |
| rdAddr | output | 32 | Read-side address counter, 8-byte aligned |
| rdRspValid | input | 1 | Read data valid, the cycle after acceptance or later |
| rdRspData | input | 64 | Read beat data |
| perReq | input | 1 | Peripheral request level |
| wrValid | output | 1 | Word offered to the peripheral |
| wrReady | input | 1 | Peripheral port accepts the word |
| wrAddr | output | 32 | Write-side address counter, 4-byte aligned |
| wrData | output | 32 | Word being written |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | At least one descriptor is held |

## Verification
The assertions assume that memory returns exactly one response for each accepted request, no earlier than the cycle after acceptance. They also assume that start addresses are word aligned and that the FIFO depth is a power of two. The bench's memory model answers every accepted beat in the very next cycle, and it keeps answering after an abort so that the discard path is exercised. All generated addresses are built with bits [1:0] forced to zero. Random ready levels on both ports and on `perReq` stress the pacing and back-pressure paths, but they never produce a response without a request.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  typedef struct packed {
    logic              flush;
    logic              rdLoad;
    logic              rdStep;
    logic              wrLoad;
    logic              wrStep;
    logic              pushLo;
    logic              pushHi;
    logic              pop;
    logic [ADDR_W-1:0] rdBase;
    logic [ADDR_W-1:0] wrBase;
  } dmv_strobe_t;
endpackage

// File: rtl/dmv_path.sv
module dmv_path
  import dmv_pkg::*;
#(
  parameter int FifoDepth = 8,
  localparam int PtrW = $clog2(FifoDepth),
  localparam int CntW = PtrW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmv_strobe_t       stb,
  input  logic [63:0]       rspData,
  output logic [CntW-1:0]   fifoCount,
  output logic [31:0]       headWord,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);
  // Word FIFO; depth must be a power of two so pointers wrap naturally.
  logic [31:0]     mem [FifoDepth];
  logic [PtrW-1:0] wp, rp;
  logic [CntW-1:0] cnt;
  logic [1:0]      nPush;
  logic [PtrW-1:0] hiSlot;

  assign nPush    = 2'(stb.pushLo) + 2'(stb.pushHi);
  assign hiSlot   = stb.pushLo ? wp + PtrW'(1) : wp;
  assign fifoCount = cnt;
  assign headWord  = mem[rp];

  always_ff @(posedge clk) begin
    if (!stb.flush) begin
      if (stb.pushLo) mem[wp]     <= rspData[31:0];
      if (stb.pushHi) mem[hiSlot] <= rspData[63:32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (stb.flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      wp  <= wp + PtrW'(nPush);
      rp  <= rp + PtrW'(stb.pop);
      cnt <= cnt + CntW'(nPush) - CntW'(stb.pop);
    end
  end

  // Independent address counters: doubleword steps on the read side, word steps on the write side.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0; wrAddr <= '0;
    end else if (stb.flush) begin
      rdAddr <= '0; wrAddr <= '0;
    end else begin
      if (stb.rdLoad)      rdAddr <= stb.rdBase & ~ADDR_W'(7);
      else if (stb.rdStep) rdAddr <= rdAddr + ADDR_W'(8);
      if (stb.wrLoad)      wrAddr <= stb.wrBase & ~ADDR_W'(3);
      else if (stb.wrStep) wrAddr <= wrAddr + ADDR_W'(4);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.flush |-> (int'(cnt) + int'(nPush) - int'(stb.pop)) <= FifoDepth);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> cnt != '0);
endmodule

// File: rtl/dmv_ctrl.sv
module dmv_ctrl
  import dmv_pkg::*;
#(
  parameter int FifoDepth = 8,
  localparam int CntW = $clog2(FifoDepth) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abort,
  input  logic              startValid,
  output logic              startReady,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  output logic              rdReq,
  input  logic              rdReady,
  input  logic              rdRspValid,
  input  logic              perReq,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [CntW-1:0]   fifoCount,
  output dmv_strobe_t       stb,
  output logic              done,
  output logic              busy
);
  // Two-slot descriptor queue shared by the read and write sides.
  logic [ADDR_W-1:0] qAddr [2];
  logic [LEN_W-1:0]  qLen  [2];
  logic              qHead;
  logic [1:0]        qCnt;
  logic [1:0]        rdOff;      // queued entries whose reads are complete

  logic              rdBusy, rdSkipLo, waiting, dropOne, wrBusy, doneQ;
  logic [LEN_W-1:0]  rdLeft, wrLeft;
  logic [1:0]        pendMask, beatMask;
  logic [LEN_W-1:0]  beatWords;
  logic [CntW:0]     fill;
  logic              enq, rdLoad, rdFire, rdLast, wrFire, wrLast, wrLoadIdle, wrLoadNext, roomOk;
  logic              rdIdx, tailIdx;

  assign startReady = (qCnt != 2'd2);
  assign enq        = startValid && startReady && (startLen != '0) && !abort;
  assign tailIdx    = qHead ^ qCnt[0];
  assign rdIdx      = qHead ^ rdOff[0];

  assign rdLoad  = !rdBusy && (rdOff < qCnt) && !abort;
  assign fill    = {1'b0, fifoCount} + (waiting ? (CntW+1)'(2) : '0);
  assign roomOk  = (fill + (CntW+1)'(2)) <= (CntW+1)'(FifoDepth);
  assign rdReq   = rdBusy && (!waiting || rdRspValid) && !dropOne && roomOk && !abort;
  assign rdFire  = rdReq && rdReady;

  always_comb begin
    if (rdSkipLo)            begin beatMask = 2'b10; beatWords = LEN_W'(1); end
    else if (rdLeft == LEN_W'(1)) begin beatMask = 2'b01; beatWords = LEN_W'(1); end
    else                     begin beatMask = 2'b11; beatWords = LEN_W'(2); end
  end
  assign rdLast = rdFire && (rdLeft == beatWords);

  assign wrValid    = wrBusy && (fifoCount != '0) && perReq && !abort;
  assign wrFire     = wrValid && wrReady;
  assign wrLast     = wrFire && (wrLeft == LEN_W'(1));
  assign wrLoadIdle = !wrBusy && (qCnt != 2'd0) && !abort;
  assign wrLoadNext = wrLast && (qCnt == 2'd2);

  always_comb begin
    stb        = '0;
    stb.flush  = abort;
    stb.rdLoad = rdLoad;
    stb.rdBase = qAddr[rdIdx];
    stb.rdStep = rdFire;
    stb.wrLoad = wrLoadIdle || wrLoadNext;
    stb.wrBase = wrLoadNext ? qAddr[~qHead] : qAddr[qHead];
    stb.wrStep = wrFire;
    stb.pushLo = rdRspValid && waiting && !abort && pendMask[0];
    stb.pushHi = rdRspValid && waiting && !abort && pendMask[1];
    stb.pop    = wrFire;
  end

  assign done = doneQ;
  assign busy = (qCnt != 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qAddr[0] <= '0; qAddr[1] <= '0; qLen[0] <= '0; qLen[1] <= '0;
      qHead <= 1'b0; qCnt <= '0; rdOff <= '0;
      rdBusy <= 1'b0; rdSkipLo <= 1'b0; rdLeft <= '0;
      waiting <= 1'b0; pendMask <= '0; dropOne <= 1'b0;
      wrBusy <= 1'b0; wrLeft <= '0; doneQ <= 1'b0;
    end else if (abort) begin
      qHead <= 1'b0; qCnt <= '0; rdOff <= '0;
      rdBusy <= 1'b0; rdSkipLo <= 1'b0; rdLeft <= '0;
      waiting <= 1'b0; pendMask <= '0;
      dropOne <= waiting && !rdRspValid;
      wrBusy <= 1'b0; wrLeft <= '0; doneQ <= 1'b0;
    end else begin
      if (enq) begin
        qAddr[tailIdx] <= startAddr;
        qLen[tailIdx]  <= startLen;
      end
      if (wrLast) qHead <= ~qHead;
      qCnt  <= qCnt + 2'(enq) - 2'(wrLast);
      rdOff <= rdOff + 2'(rdLast) - 2'(wrLast);

      if (rdLoad) begin
        rdBusy   <= 1'b1;
        rdLeft   <= qLen[rdIdx];
        rdSkipLo <= qAddr[rdIdx][2];
      end else if (rdFire) begin
        rdLeft   <= rdLeft - beatWords;
        rdSkipLo <= 1'b0;
        if (rdLast) rdBusy <= 1'b0;
      end

      if (rdFire) begin
        waiting  <= 1'b1;
        pendMask <= beatMask;
      end else if (rdRspValid) begin
        waiting  <= 1'b0;
      end
      if (rdRspValid) dropOne <= 1'b0;

      if (wrLoadIdle) begin
        wrBusy <= 1'b1;
        wrLeft <= qLen[qHead];
      end else if (wrLoadNext) begin
        wrLeft <= qLen[~qHead];
      end else if (wrLast) begin
        wrBusy <= 1'b0;
      end else if (wrFire) begin
        wrLeft <= wrLeft - LEN_W'(1);
      end
      doneQ <= wrLast;
    end
  end

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && waiting) |-> rdRspValid);
  p_done_follows_word_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrValid && wrReady));
endmodule

// File: rtl/dmv_mover.sv
module dmv_mover
  import dmv_pkg::*;
#(
  parameter int FifoDepth = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abort,
  input  logic              startValid,
  output logic              startReady,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  output logic              rdReq,
  input  logic              rdReady,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdRspValid,
  input  logic [63:0]       rdRspData,
  input  logic              perReq,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              done,
  output logic              busy
);
  localparam int CntW = $clog2(FifoDepth) + 1;

  dmv_strobe_t     stb;
  logic [CntW-1:0] fifoCount;

  dmv_ctrl #(.FifoDepth(FifoDepth)) u_ctrl (
    .clk(clk), .rstN(rstN), .abort(abort),
    .startValid(startValid), .startReady(startReady),
    .startAddr(startAddr), .startLen(startLen),
    .rdReq(rdReq), .rdReady(rdReady), .rdRspValid(rdRspValid),
    .perReq(perReq), .wrValid(wrValid), .wrReady(wrReady),
    .fifoCount(fifoCount), .stb(stb), .done(done), .busy(busy)
  );

  dmv_path #(.FifoDepth(FifoDepth)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .rspData(rdRspData),
    .fifoCount(fifoCount), .headWord(wrData),
    .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  p_rd_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdReady) |=> rdAddr == $past(rdAddr) + ADDR_W'(8));
  p_write_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> perReq);
  p_abort_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && rdAddr == '0 && wrAddr == '0));
endmodule

// File: tb/sim_dmv_mover.sv
module sim_dmv_mover;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abort = 1'b0, startValid = 1'b0, startReady;
  logic [31:0] startAddr = '0;
  logic [15:0] startLen = '0;
  logic rdReq, rdReady = 1'b0, rdRspValid = 1'b0;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [63:0] rdRspData = '0;
  logic perReq = 1'b0, wrValid, wrReady = 1'b0, done, busy;

  always #5 clk = ~clk;

  dmv_mover u0 (.*);

  int nChk = 0, nFail = 0;
  int perMode = 1, wrMode = 1, rdMode = 1;   // 0 low, 1 high, 2 random
  int cyc = 0;
  int reqCount = 0, writes = 0, doneCount = 0;
  logic [31:0] firstReqAddr;
  logic reqSeen = 1'b0, prevLast = 1'b0, summaryDone = 1'b0;
  logic [31:0] reqAddrQ;
  logic [31:0] expAddr [64];
  int expLen [64];
  int expHead = 0, expCnt = 0, wIdx = 0, xferNo = 0;
  int firstCyc [64];
  int lastCyc [64];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a ^ 32'h5A00_0000 ^ {a[15:0], 16'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pick(input int mode);
    return (mode == 2) ? bit'($urandom_range(0, 1)) : bit'(mode == 1);
  endfunction

  always @(posedge clk) cyc++;

  // Level drivers for the peripheral side.
  always @(negedge clk) begin
    perReq  = pick(perMode);
    wrReady = pick(wrMode);
  end

  // Memory: answers each accepted beat in the following cycle.
  always @(negedge clk) begin
    if (reqSeen) begin
      rdRspValid = 1'b1;
      rdRspData  = {memWord(reqAddrQ + 32'd4), memWord(reqAddrQ)};
    end else begin
      rdRspValid = 1'b0;
    end
    reqSeen = 1'b0;
    rdReady = pick(rdMode);
    #1;
    if (rdReq && rdReady) begin
      reqSeen  = 1'b1;
      reqAddrQ = rdAddr;
      if (reqCount == 0) firstReqAddr = rdAddr;
      reqCount++;
      chk(rdAddr[2:0] == 3'b0, "R2 read address aligned", rdAddr, rdAddr & ~32'd7);
    end
  end

  // Write-port monitor and done checker.
  always @(negedge clk) begin
    #1;
    if (done || prevLast) chk(done == prevLast, "R9 done pulse", 32'(done), 32'(prevLast));
    if (done) doneCount++;
    prevLast = 1'b0;
    if (!perReq) chk(!wrValid, "R6 no write without request level", 32'(wrValid), 32'd0);
    if (wrValid && wrReady) begin
      writes++;
      if (expCnt == 0) begin
        chk(1'b0, "R3 unexpected write", wrAddr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] a;
        a = expAddr[expHead] + 32'(4 * wIdx);
        chk(wrAddr == a, "R3 write address", wrAddr, a);
        chk(wrData == memWord(a), "R3/R4 write data", wrData, memWord(a));
        if (wIdx == 0) firstCyc[xferNo % 64] = cyc;
        wIdx++;
        if (wIdx == expLen[expHead]) begin
          lastCyc[xferNo % 64] = cyc;
          xferNo++;
          expHead = (expHead + 1) % 64;
          expCnt--;
          wIdx = 0;
          prevLast = 1'b1;
        end
      end
    end
  end

  task automatic push(input logic [31:0] a, input int len);
    @(negedge clk);
    startValid = 1'b1; startAddr = a; startLen = 16'(len);
    #1;
    while (!startReady) begin @(negedge clk); #1; end
    if (len != 0) begin
      expAddr[(expHead + expCnt) % 64] = a;
      expLen[(expHead + expCnt) % 64]  = len;
      expCnt++;
    end
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expCnt != 0 || busy) && n < 20000) begin @(negedge clk); #2; n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    finishRun();
  end

  initial begin
    int d0, w0, r0, x0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(!busy && !rdReq && !wrValid && !done, "R1 idle outputs", {busy, rdReq, wrValid, done}, 32'd0);
    chk(startReady, "R1 startReady", 32'(startReady), 32'd1);
    chk(rdAddr == 0 && wrAddr == 0, "R1 counters", rdAddr | wrAddr, 32'd0);

    // R2/R3 aligned transfer
    d0 = doneCount; w0 = writes; reqCount = 0;
    push(32'h0000_0100, 8);
    drain();
    chk(firstReqAddr == 32'h100, "R2 first read address", firstReqAddr, 32'h100);
    chk(reqCount == 4, "R2 beat count", 32'(reqCount), 32'd4);
    chk(writes - w0 == 8, "R3 word count", 32'(writes - w0), 32'd8);
    chk(doneCount - d0 == 1, "R9 one done", 32'(doneCount - d0), 32'd1);

    // R4/R5 unaligned start, odd count
    d0 = doneCount; w0 = writes; reqCount = 0;
    push(32'h0000_0204, 5);
    drain();
    chk(firstReqAddr == 32'h200, "R4 first beat base", firstReqAddr, 32'h200);
    chk(reqCount == 3, "R5 beats for five words", 32'(reqCount), 32'd3);
    chk(writes - w0 == 5, "R5 exact word count", 32'(writes - w0), 32'd5);

    // R7 zero length
    d0 = doneCount; w0 = writes; reqCount = 0;
    push(32'h0000_0300, 0);
    repeat (20) @(negedge clk);
    #2;
    chk(reqCount == 0 && writes == w0, "R7 no traffic", 32'(reqCount + writes - w0), 32'd0);
    chk(!busy && doneCount == d0, "R7 no done", 32'(busy) + 32'(doneCount - d0), 32'd0);

    // R6/R8 request level held low
    perMode = 0; d0 = doneCount; w0 = writes; reqCount = 0;
    push(32'h0000_0400, 20);
    repeat (40) @(negedge clk);
    #2;
    chk(writes == w0, "R6 writes while level low", 32'(writes - w0), 32'd0);
    chk(reqCount == 4, "R8 beats until FIFO full", 32'(reqCount), 32'd4);
    perMode = 1;
    drain();
    chk(writes - w0 == 20, "R6 stream after level rises", 32'(writes - w0), 32'd20);
    chk(doneCount - d0 == 1, "R9 done after stream", 32'(doneCount - d0), 32'd1);

    // R10 two queued descriptors, back to back
    x0 = xferNo;
    push(32'h0000_1000, 6);
    push(32'h0000_2004, 3);
    #2;
    chk(!startReady, "R10 both slots held", 32'(startReady), 32'd0);
    drain();
    chk(lastCyc[x0 % 64] + 1 == firstCyc[(x0 + 1) % 64], "R10 no gap",
        32'(firstCyc[(x0 + 1) % 64]), 32'(lastCyc[x0 % 64] + 1));

    // R11 abort mid-transfer
    w0 = writes;
    push(32'h0000_0800, 30);
    while (writes - w0 < 5) @(negedge clk);
    @(negedge clk);
    abort = 1'b1; expCnt = 0; wIdx = 0; prevLast = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    #2;
    chk(!busy && !wrValid && startReady, "R11 idle after abort", {busy, wrValid, startReady}, 32'd1);
    chk(rdAddr == 0 && wrAddr == 0, "R11 counters cleared", rdAddr | wrAddr, 32'd0);
    r0 = writes;
    repeat (6) @(negedge clk);
    #2;
    chk(writes == r0, "R11 no writes after abort", 32'(writes - r0), 32'd0);
    d0 = doneCount;
    push(32'h0000_0904, 4);
    drain();
    chk(doneCount - d0 == 1, "R11 clean restart", 32'(doneCount - d0), 32'd1);

    // Random descriptors with random pacing (R3/R4/R5/R6/R9 via monitor)
    perMode = 2; wrMode = 2; rdMode = 2;
    d0 = doneCount;
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a;
      a = {16'h0, 14'($urandom), 2'b00};
      push(a, $urandom_range(1, 40));
    end
    drain();
    chk(doneCount - d0 == 20, "R9 done per random transfer", 32'(doneCount - d0), 32'd20);
    chk(expCnt == 0, "R3 all random words written", 32'(expCnt), 32'd0);
    finishRun();
  end
endmodule